// File: doc/BRIEF.md
# Prioritized Interrupt Acknowledge Controller

This block sits beside a processor's instruction sequencer and decides whether an incoming interrupt request should be taken. Requests arrive as a three-bit level on active-low lines. The block compares that level with the priority mask in the status register and raises a request toward the sequencer when the level is high enough to interrupt. When the sequencer grants at an instruction boundary, the block captures the level and a copy of the status register. It then runs a dedicated acknowledge bus cycle to obtain an interrupt vector.

During the acknowledge cycle the captured level is placed on address bits 3..1, and every other address bit is driven high. A device answers in one of two ways. It can assert its data acknowledge and return its own vector on the low byte of the data bus. It can instead assert the autovector request, in which case the vector is formed from a fixed base plus the level. If the device answers with both signals, or with neither before a time limit, the spurious vector is used. The block then presents four results to the sequencer: the vector number, the vector table address, the status register as it was before entry, and the status register to load for the handler. Stacking and the handler fetch belong to the sequencer.

Top module: `iack_ctrl`

## Requirements
- R1: `int_req` is high exactly when the requested level (the bitwise inverse of `ipl_n`) is greater than the mask in status bits 10..8, or when the level is 7. Level 0 never raises it.
- R2: A `grant` taken while `int_req` is low has no effect: `bus_strobe` and `ack_done` stay low.
- R3: A grant taken while `int_req` is high raises `bus_strobe` one cycle later. While the strobe is high, `bus_addr[3:1]` carries the accepted level and every other address bit is 1. While it is low, `bus_addr` is 0.
- R4: When `dtack_n` is low and `vpa_n` is high during the strobe, `vec_num` equals `bus_vec_in`, and `vec_addr` equals 4 × `vec_num`.
- R5: When `vpa_n` is low and `dtack_n` is high during the strobe, `vec_num` equals 24 + level.
- R6: `sr_new` is the captured status word with bit 15 (trace) cleared, bit 13 (supervisor) set, bits 10..8 set to the accepted level, and all other bits unchanged.
- R7: `sr_saved` is the status word present at the grant edge. Later changes of `sr_in` do not alter it or `sr_new`.
- R8: If `dtack_n` and `vpa_n` are low in the same cycle, `proto_err` pulses together with `ack_done` and `vec_num` is 24.
- R9: If no response arrives, the strobe stays high for exactly 64 cycles. The cycle then ends with `vec_num` 24 and `proto_err` low.
- R10: `ack_done` is a single-cycle pulse in the cycle after the response is sampled. The strobe is low from that cycle on.
- R11: The level is fixed at the grant edge. Changes on `ipl_n` during the strobe do not alter `bus_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ipl_n | input | 3 | Requested interrupt level, active low |
| sr_in | input | 16 | Current status register |
| grant | input | 1 | Sequencer accepts the request (one-cycle pulse) |
| int_req | output | 1 | An interrupt should be taken |
| bus_addr | output | 24 | Address during the acknowledge cycle |
| bus_strobe | output | 1 | Acknowledge cycle in progress |
| bus_vec_in | input | 8 | Low byte of the data bus |
| dtack_n | input | 1 | Device data acknowledge, active low |
| vpa_n | input | 1 | Autovector request, active low |
| ack_done | output | 1 | Results valid (one-cycle pulse) |
| vec_num | output | 8 | Vector number |
| vec_addr | output | 24 | Vector table address, 4 × vector |
| sr_new | output | 16 | Status word to load for the handler |
| sr_saved | output | 16 | Status word captured before modification |
| proto_err | output | 1 | Both acknowledges were seen together |

## Verification
`int_req` is combinational from `ipl_n` and `sr_in`, so each task reads it half a cycle after changing those inputs. The strobe and the address are registered from the grant edge, so they are read at the first falling edge after that edge. A response driven at a falling edge is sampled at the next rising edge. `ack_done` and all results are therefore read at the falling edge that follows, and a further falling edge confirms that the pulse has ended and the strobe is low. For the timeout case, the bench counts falling edges with the strobe high until `ack_done` appears and expects 64.

// File: rtl/iack_pkg.sv
package iack_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACK  = 2'd1,
      ST_DONE = 2'd2
   } iack_state_e;

   typedef enum logic [1:0] {
      RSP_NONE  = 2'd0,
      RSP_DEV   = 2'd1,
      RSP_AUTO  = 2'd2,
      RSP_CLASH = 2'd3
   } iack_rsp_e;

endpackage

// File: rtl/iack_prio.sv
module iack_prio #(
   parameter int LVL_W  = 3,
   parameter bit NMI_EN = 1'b1
) (
   input  logic [LVL_W-1:0] ipl_n,
   input  logic [LVL_W-1:0] mask,
   output logic [LVL_W-1:0] level,
   output logic             pend
);
   logic above;

   assign level = ~ipl_n;
   assign above = (level > mask);

   generate
      if (NMI_EN) begin : g_nmi
         assign pend = above | (&level);
      end else begin : g_plain
         assign pend = above;
      end
   endgenerate
endmodule

// File: rtl/iack_timer.sv
module iack_timer #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CNT_W = (LIMIT > 2) ? $clog2(LIMIT) : 1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (run) cnt_q <= cnt_q + 1'b1;
      else          cnt_q <= '0;
   end

   assign expired = run && (cnt_q == CNT_W'(LIMIT - 1));
endmodule

// File: rtl/iack_resp.sv
module iack_resp
   import iack_pkg::*;
#(
   parameter int LVL_W      = 3,
   parameter int VEC_W      = 8,
   parameter int AUTO_BASE  = 24,
   parameter int SPUR_VEC   = 24
) (
   input  logic             dtack_n,
   input  logic             vpa_n,
   input  logic             expired,
   input  logic [LVL_W-1:0] level,
   input  logic [VEC_W-1:0] dev_vec,
   output logic             fire,
   output logic             clash,
   output logic [VEC_W-1:0] vec
);
   iack_rsp_e kind;

   always_comb begin
      unique case ({!dtack_n, !vpa_n})
         2'b10:   kind = RSP_DEV;
         2'b01:   kind = RSP_AUTO;
         2'b11:   kind = RSP_CLASH;
         default: kind = RSP_NONE;
      endcase
   end

   always_comb begin
      unique case (kind)
         RSP_DEV:  vec = dev_vec;
         RSP_AUTO: vec = VEC_W'(AUTO_BASE) + VEC_W'(level);
         default:  vec = VEC_W'(SPUR_VEC);
      endcase
   end

   assign clash = (kind == RSP_CLASH);
   assign fire  = (kind != RSP_NONE) || expired;
endmodule

// File: rtl/iack_ctrl.sv
module iack_ctrl
   import iack_pkg::*;
#(
   parameter int ADDR_W    = 24,
   parameter int SR_W      = 16,
   parameter int LVL_W     = 3,
   parameter int VEC_W     = 8,
   parameter int MASK_LSB  = 8,
   parameter int SUP_BIT   = 13,
   parameter int TRC_BIT   = 15,
   parameter int AUTO_BASE = 24,
   parameter int SPUR_VEC  = 24,
   parameter int TIMEOUT   = 64,
   parameter bit NMI_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  ipl_n,
   input  logic [SR_W-1:0]   sr_in,
   input  logic              grant,
   output logic              int_req,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_strobe,
   input  logic [VEC_W-1:0]  bus_vec_in,
   input  logic              dtack_n,
   input  logic              vpa_n,
   output logic              ack_done,
   output logic [VEC_W-1:0]  vec_num,
   output logic [ADDR_W-1:0] vec_addr,
   output logic [SR_W-1:0]   sr_new,
   output logic [SR_W-1:0]   sr_saved,
   output logic              proto_err
);
   localparam int MASK_MSB = MASK_LSB + LVL_W - 1;
   localparam int PAD_W    = ADDR_W - VEC_W - 2;

   initial begin
      assert (ADDR_W >= VEC_W + 2) else $fatal(1, "address too narrow for vector table");
      assert (ADDR_W >= LVL_W + 2) else $fatal(1, "address too narrow for level field");
      assert (MASK_MSB < SR_W)     else $fatal(1, "mask field outside status word");
      assert (TIMEOUT >= 2)        else $fatal(1, "timeout too short");
      assert (AUTO_BASE + (1 << LVL_W) <= (1 << VEC_W)) else $fatal(1, "autovector overflows");
   end

   iack_state_e      state_q;
   logic [LVL_W-1:0] lvl_now, lvl_q;
   logic             pend;
   logic             expired, fire, clash;
   logic [VEC_W-1:0] vec_sel, vec_q;
   logic             err_q;
   logic [SR_W-1:0]  sr_q;
   logic [ADDR_W-1:0] ack_addr;
   logic             take;

   iack_prio #(.LVL_W(LVL_W), .NMI_EN(NMI_EN)) prio_i (
      .ipl_n (ipl_n),
      .mask  (sr_in[MASK_MSB:MASK_LSB]),
      .level (lvl_now),
      .pend  (pend)
   );

   iack_timer #(.LIMIT(TIMEOUT)) timer_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (state_q == ST_ACK),
      .expired (expired)
   );

   iack_resp #(
      .LVL_W(LVL_W), .VEC_W(VEC_W), .AUTO_BASE(AUTO_BASE), .SPUR_VEC(SPUR_VEC)
   ) resp_i (
      .dtack_n (dtack_n),
      .vpa_n   (vpa_n),
      .expired (expired),
      .level   (lvl_q),
      .dev_vec (bus_vec_in),
      .fire    (fire),
      .clash   (clash),
      .vec     (vec_sel)
   );

   assign take = (state_q == ST_IDLE) && grant && pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         lvl_q   <= '0;
         sr_q    <= '0;
         vec_q   <= '0;
         err_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (take) begin
               state_q <= ST_ACK;
               lvl_q   <= lvl_now;
               sr_q    <= sr_in;
            end
            ST_ACK: if (fire) begin
               state_q <= ST_DONE;
               vec_q   <= vec_sel;
               err_q   <= clash;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // acknowledge address: level on bits [LVL_W:1], ones everywhere else
   generate
      for (genvar b = 0; b < ADDR_W; b++) begin : g_abit
         if (b >= 1 && b <= LVL_W) begin : g_lvl
            assign ack_addr[b] = lvl_q[b-1];
         end else begin : g_one
            assign ack_addr[b] = 1'b1;
         end
      end
   endgenerate

   // status word for handler entry
   always_comb begin
      sr_new                    = sr_q;
      sr_new[TRC_BIT]           = 1'b0;
      sr_new[SUP_BIT]           = 1'b1;
      sr_new[MASK_MSB:MASK_LSB] = lvl_q;
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign vec_addr = {{PAD_W{1'b0}}, vec_q, 2'b00};
      end else begin : g_nopad
         assign vec_addr = {vec_q, 2'b00};
      end
   endgenerate

   assign int_req    = pend;
   assign bus_strobe = (state_q == ST_ACK);
   assign bus_addr   = bus_strobe ? ack_addr : '0;
   assign ack_done   = (state_q == ST_DONE);
   assign vec_num    = vec_q;
   assign sr_saved   = sr_q;
   assign proto_err  = ack_done && err_q;
endmodule

// File: rtl/iack_ctrl_chk.sv
module iack_ctrl_chk #(
   parameter int ADDR_W   = 24,
   parameter int SR_W     = 16,
   parameter int LVL_W    = 3,
   parameter int VEC_W    = 8,
   parameter int SUP_BIT  = 13,
   parameter int TRC_BIT  = 15,
   parameter int SPUR_VEC = 24,
   parameter int TIMEOUT  = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LVL_W-1:0]  ipl_n,
   input logic              int_req,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_strobe,
   input logic              ack_done,
   input logic [VEC_W-1:0]  vec_num,
   input logic [SR_W-1:0]   sr_new,
   input logic              proto_err
);
   logic [15:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run_q <= '0;
      else if (bus_strobe) run_q <= run_q + 1'b1;
      else                 run_q <= '0;
   end

   // R1
   no_level0_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> (ipl_n != {LVL_W{1'b1}}));

   // R3
   ack_addr_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_strobe |-> (bus_addr[LVL_W:1] != '0) && bus_addr[0] && (&bus_addr[ADDR_W-1:LVL_W+1]));

   // R3
   idle_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_strobe |-> (bus_addr == '0));

   // R11
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_strobe && $past(bus_strobe) |-> $stable(bus_addr));

   // R6
   entry_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_done |-> !sr_new[TRC_BIT] && sr_new[SUP_BIT]);

   // R8
   clash_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> ack_done && (vec_num == VEC_W'(SPUR_VEC)));

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_done |=> !ack_done && !bus_strobe);

   // R10
   done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_done && bus_strobe));

   // R9
   strobe_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= 16'(TIMEOUT));
endmodule

bind iack_ctrl iack_ctrl_chk #(
   .ADDR_W(ADDR_W), .SR_W(SR_W), .LVL_W(LVL_W), .VEC_W(VEC_W),
   .SUP_BIT(SUP_BIT), .TRC_BIT(TRC_BIT), .SPUR_VEC(SPUR_VEC), .TIMEOUT(TIMEOUT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .ipl_n(ipl_n), .int_req(int_req),
   .bus_addr(bus_addr), .bus_strobe(bus_strobe), .ack_done(ack_done),
   .vec_num(vec_num), .sr_new(sr_new), .proto_err(proto_err)
);

// File: tb/iack_ctrl_tb_top.sv
module iack_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  ipl_n = 3'b111;
   logic [15:0] sr_in = 16'h2700;
   logic        grant = 1'b0;
   logic        int_req;
   logic [23:0] bus_addr;
   logic        bus_strobe;
   logic [7:0]  bus_vec_in = 8'h00;
   logic        dtack_n = 1'b1;
   logic        vpa_n = 1'b1;
   logic        ack_done;
   logic [7:0]  vec_num;
   logic [23:0] vec_addr;
   logic [15:0] sr_new;
   logic [15:0] sr_saved;
   logic        proto_err;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   iack_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .ipl_n(ipl_n), .sr_in(sr_in), .grant(grant),
      .int_req(int_req), .bus_addr(bus_addr), .bus_strobe(bus_strobe),
      .bus_vec_in(bus_vec_in), .dtack_n(dtack_n), .vpa_n(vpa_n),
      .ack_done(ack_done), .vec_num(vec_num), .vec_addr(vec_addr),
      .sr_new(sr_new), .sr_saved(sr_saved), .proto_err(proto_err)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] entry_sr(logic [15:0] sr, logic [2:0] lvl);
      return (sr & ~16'h8700) | 16'h2000 | (16'(lvl) << 8);
   endfunction

   // rsp: 0 none, 1 device, 2 autovector, 3 both
   task automatic run_ack(string tag, logic [2:0] lvl, logic [15:0] sr, int rsp,
                          logic [7:0] dvec, int dly);
      logic [7:0] exp_vec;
      int strobes;
      ipl_n = ~lvl;
      sr_in = sr;
      @(negedge clk);
      check({tag, " R1 int_req"}, int_req, 1);
      grant = 1'b1;
      @(negedge clk);
      grant = 1'b0;
      check({tag, " R3 strobe"}, bus_strobe, 1);
      check({tag, " R3 addr"}, bus_addr, 24'hFFFFF1 | (24'(lvl) << 1));
      sr_in = 16'h0000;                 // R7 late change
      ipl_n = 3'b000;                   // R11 late change
      bus_vec_in = dvec;
      if (rsp == 0) begin
         strobes = 0;
         for (int i = 0; i < 200 && !ack_done; i++) begin
            if (bus_strobe) strobes++;
            @(negedge clk);
         end
         check({tag, " R9 strobe cycles"}, strobes, 64);
         exp_vec = 8'd24;
      end else begin
         for (int i = 0; i < dly; i++) @(negedge clk);
         check({tag, " R11 addr held"}, bus_addr, 24'hFFFFF1 | (24'(lvl) << 1));
         dtack_n = !(rsp == 1 || rsp == 3);
         vpa_n   = !(rsp == 2 || rsp == 3);
         @(negedge clk);
         dtack_n = 1'b1;
         vpa_n = 1'b1;
         exp_vec = (rsp == 1) ? dvec : (rsp == 2) ? 8'(24 + lvl) : 8'd24;
      end
      check({tag, " R10 done"}, ack_done, 1);
      check({tag, " R10 strobe low"}, bus_strobe, 0);
      check({tag, " R4/R5 vec_num"}, vec_num, exp_vec);
      check({tag, " R4 vec_addr"}, vec_addr, 24'(exp_vec) * 4);
      check({tag, " R6 sr_new"}, sr_new, entry_sr(sr, lvl));
      check({tag, " R7 sr_saved"}, sr_saved, sr);
      check({tag, " R8 proto_err"}, proto_err, rsp == 3);
      @(negedge clk);
      check({tag, " R10 done pulse"}, ack_done, 0);
      check({tag, " R3 addr idle"}, bus_addr, 0);
      ipl_n = 3'b111;
   endtask

   task automatic test_reset;
      check("R3 reset strobe", bus_strobe, 0);
      check("R10 reset done", ack_done, 0);
      check("R3 reset addr", bus_addr, 0);
   endtask

   task automatic test_pending;
      sr_in = 16'h2300;
      ipl_n = ~3'd3; #1 check("R1 equal level blocked", int_req, 0);
      ipl_n = ~3'd4; #1 check("R1 higher level", int_req, 1);
      ipl_n = ~3'd2; #1 check("R1 lower level", int_req, 0);
      sr_in = 16'h0000;
      ipl_n = 3'b111; #1 check("R1 level 0", int_req, 0);
      sr_in = 16'h2700;
      ipl_n = ~3'd7; #1 check("R1 level 7 at mask 7", int_req, 1);
      ipl_n = ~3'd6; #1 check("R1 level 6 at mask 7", int_req, 0);
      ipl_n = 3'b111;
      @(negedge clk);
   endtask

   task automatic test_ignored_grant;
      sr_in = 16'h0500;
      ipl_n = ~3'd5;
      @(negedge clk);
      grant = 1'b1;
      @(negedge clk);
      grant = 1'b0;
      check("R2 strobe stays low", bus_strobe, 0);
      @(negedge clk);
      check("R2 strobe low later", bus_strobe, 0);
      check("R2 no done", ack_done, 0);
      ipl_n = 3'b111;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_pending();
      test_ignored_grant();
      run_ack("device", 3'd4, 16'h8315, 1, 8'h40, 2);
      run_ack("device0", 3'd2, 16'h0000, 1, 8'hFF, 0);
      run_ack("auto", 3'd6, 16'h2519, 2, 8'h00, 3);
      run_ack("auto_nmi", 3'd7, 16'hA71F, 2, 8'h00, 1);
      run_ack("clash", 3'd5, 16'h0200, 3, 8'h77, 1);
      run_ack("timeout", 3'd1, 16'h8000, 0, 8'h00, 0);
      finished = 1'b1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule